// File: doc/BRIEF.md
# Retrace-Synchronized Cursor Overlay

This block paints a small square cursor over a stream of display pixels. A bitmap store holds one 16-bit code per cursor pixel and is filled through a simple write port. Each code selects one of three treatments of the underlying pixel: it can be left alone, replaced by a fixed RGB555 colour, or inverted.

The host writes the cursor position and a visibility bit into shadow registers. The overlay logic never uses these shadow copies directly. It copies them into its working registers only while the vertical-blank input is high, so a move or a show/hide request never takes effect partway through a frame.

Each cycle the block takes the current raster coordinates and the underlying pixel. It decides whether that raster point falls inside the cursor square, looks up the bitmap code for the matching cursor pixel, and produces the final pixel one clock later.

Top module: `cursor_overlay`

## Requirements
- R1: The bitmap holds 32x32 codes of 16 bits. The code for cursor row r, column c is written at address r*32+c through the bitmap write port, and later writes replace earlier ones.
- R2: A code of 0x0000 is transparent: the output equals the underlying pixel.
- R3: A code with bit 15 set is opaque. The output is bit 15 cleared with bits 14:0 taken from the code, so 0xFFFF gives 0x7FFF (white) and 0x8000 gives 0x0000 (black).
- R4: A nonzero code with bit 15 clear (for example 0x7FFF) inverts the underlying pixel: the output is its bitwise complement.
- R5: The position word carries x in bits 11:0 and y in bits 27:16. A raster point is inside the cursor only when raster minus position lies in 0..31 on both axes, with no wrap past coordinate 0. Outside the cursor the output equals the underlying pixel.
- R6: Bit 0 of the control word enables the cursor. While the working enable is 0, the output equals the underlying pixel everywhere.
- R7: Host writes of position and control go to shadow registers only. The working position and enable copy the shadow values on every clock edge at which vertical blank is high, and hold otherwise.
- R8: A control write with no position write changes visibility at the next vertical blank.
- R9: The output pixel is registered, one cycle after the raster inputs. Reset clears the output, the working and shadow position, and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bmp_we | input | 1 | Bitmap write strobe |
| bmp_addr | input | 10 | Bitmap write address, row*32+column |
| bmp_wdata | input | 16 | Bitmap code to store |
| pos_we | input | 1 | Shadow position write strobe |
| pos_wdata | input | 32 | Position word, x in 11:0, y in 27:16 |
| ctrl_we | input | 1 | Shadow control write strobe |
| ctrl_wdata | input | 32 | Control word, bit 0 enables the cursor |
| vblank | input | 1 | Vertical blank; working registers load while high |
| ras_x | input | 12 | Current raster column |
| ras_y | input | 12 | Current raster row |
| pix_in | input | 16 | Underlying pixel |
| pix_out | output | 16 | Final pixel, one cycle later |

## Verification
The bench builds the block with its default parameters: a 32-pixel cursor, 12-bit coordinates and 16-bit pixels. With 12-bit coordinates the raster can reach the far edge at 4095, so the bench places cursors that hang off the right and bottom of the coordinate space and drives raster points just past zero to show that the window does not wrap. The 32-pixel square keeps a full bitmap load at 1024 writes, so every code class fills known cells. Position and control writes are issued both inside and outside vertical blank, so the hold and copy timing of the working registers is exercised against a reference model.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int COORD_W   = 12;
  localparam int PIX_W     = 16;
  localparam int CUR_DIM   = 32;
  localparam int REG_W     = 32;
  localparam int POS_X_LSB = 0;
  localparam int POS_Y_LSB = 16;
  localparam int EN_BIT    = 0;

  // Unsigned offset of the raster from the cursor origin; negative wraps high.
  function automatic logic [COORD_W:0] axis_off(input logic [COORD_W-1:0] ras,
                                                input logic [COORD_W-1:0] org);
    return {1'b0, ras} - {1'b0, org};
  endfunction

  // Combine one cursor code with the underlying pixel.
  function automatic logic [PIX_W-1:0] blend(input logic [PIX_W-1:0] code,
                                             input logic [PIX_W-1:0] under);
    if (code == '0)             return under;
    else if (code[PIX_W-1])     return {1'b0, code[PIX_W-2:0]};
    else                        return ~under;
  endfunction
endpackage

// File: rtl/cursor_bitmap.sv
module cursor_bitmap #(
  parameter int PIX_W  = cursor_pkg::PIX_W,
  parameter int DEPTH  = cursor_pkg::CUR_DIM * cursor_pkg::CUR_DIM,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int CW = COORD_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pos_we,
  input  logic [RW-1:0] pos_wdata,
  input  logic          ctrl_we,
  input  logic [RW-1:0] ctrl_wdata,
  input  logic          vblank,
  output logic [CW-1:0] act_x,
  output logic [CW-1:0] act_y,
  output logic          act_en
);
  logic [CW-1:0] shd_x, shd_y;
  logic          shd_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_x <= '0; shd_y <= '0; shd_en <= 1'b0;
      act_x <= '0; act_y <= '0; act_en <= 1'b0;
    end else begin
      if (pos_we) begin
        shd_x <= pos_wdata[POS_X_LSB +: CW];
        shd_y <= pos_wdata[POS_Y_LSB +: CW];
      end
      if (ctrl_we) shd_en <= ctrl_wdata[EN_BIT];
      if (vblank) begin
        act_x  <= shd_x;
        act_y  <= shd_y;
        act_en <= shd_en;
      end
    end
  end

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> ($stable(act_x) && $stable(act_y) && $stable(act_en)));

  // R8
  en_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !$past(vblank) && $past(ctrl_we)) |=> act_en == $past(ctrl_wdata[EN_BIT], 2));
endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
  import cursor_pkg::*;
#(
  parameter int CW  = COORD_W,
  parameter int PW  = PIX_W,
  parameter int DIM = CUR_DIM,
  localparam int OFF_W = $clog2(DIM),
  localparam int AW    = 2 * OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ras_x,
  input  logic [CW-1:0] ras_y,
  input  logic [PW-1:0] pix_in,
  input  logic [CW-1:0] act_x,
  input  logic [CW-1:0] act_y,
  input  logic          act_en,
  output logic [AW-1:0] rd_addr,
  input  logic [PW-1:0] rd_code,
  output logic [PW-1:0] pix_out
);
  logic [CW:0] dx, dy;
  logic        hit;
  logic        draw;

  assign dx      = axis_off(ras_x, act_x);
  assign dy      = axis_off(ras_y, act_y);
  assign hit     = (dx < (CW+1)'(DIM)) && (dy < (CW+1)'(DIM));
  assign draw    = hit && act_en;
  assign rd_addr = {dy[OFF_W-1:0], dx[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)    pix_out <= '0;
    else if (draw) pix_out <= blend(rd_code, pix_in);
    else           pix_out <= pix_in;
  end

  // R5
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !draw |=> pix_out == $past(pix_in));

  // R3
  opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (draw && rd_code[PW-1]) |=> pix_out == {1'b0, $past(rd_code[PW-2:0])});

  // R4
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (draw && !rd_code[PW-1] && rd_code != '0) |=> pix_out == ~$past(pix_in));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (draw && rd_code == '0) |=> pix_out == $past(pix_in));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int CW  = COORD_W,
  parameter int PW  = PIX_W,
  parameter int DIM = CUR_DIM,
  parameter int RW  = REG_W,
  localparam int AW = $clog2(DIM * DIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bmp_we,
  input  logic [AW-1:0] bmp_addr,
  input  logic [PW-1:0] bmp_wdata,
  input  logic          pos_we,
  input  logic [RW-1:0] pos_wdata,
  input  logic          ctrl_we,
  input  logic [RW-1:0] ctrl_wdata,
  input  logic          vblank,
  input  logic [CW-1:0] ras_x,
  input  logic [CW-1:0] ras_y,
  input  logic [PW-1:0] pix_in,
  output logic [PW-1:0] pix_out
);
  logic [CW-1:0] act_x, act_y;
  logic          act_en;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] rd_code;

  cursor_regs #(.CW(CW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .pos_we(pos_we), .pos_wdata(pos_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .vblank(vblank),
    .act_x(act_x), .act_y(act_y), .act_en(act_en)
  );

  cursor_bitmap #(.PIX_W(PW), .DEPTH(DIM * DIM)) u_bmp (
    .clk(clk), .we(bmp_we), .waddr(bmp_addr), .wdata(bmp_wdata),
    .raddr(rd_addr), .rdata(rd_code)
  );

  cursor_mixer #(.CW(CW), .PW(PW), .DIM(DIM)) u_mix (
    .clk(clk), .rst_n(rst_n),
    .ras_x(ras_x), .ras_y(ras_y), .pix_in(pix_in),
    .act_x(act_x), .act_y(act_y), .act_en(act_en),
    .rd_addr(rd_addr), .rd_code(rd_code), .pix_out(pix_out)
  );

  // R6
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> pix_out == $past(pix_in));
endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bmp_we;
  logic [9:0]  bmp_addr;
  logic [15:0] bmp_wdata;
  logic        pos_we;
  logic [31:0] pos_wdata;
  logic        ctrl_we;
  logic [31:0] ctrl_wdata;
  logic        vblank;
  logic [11:0] ras_x, ras_y;
  logic [15:0] pix_in;
  logic [15:0] pix_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mem [1024];
  int sx, sy, sen, ax, ay, aen;
  string phase_tag = "";

  always #(CLK_P/2) clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst_n(rst_n),
    .bmp_we(bmp_we), .bmp_addr(bmp_addr), .bmp_wdata(bmp_wdata),
    .pos_we(pos_we), .pos_wdata(pos_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .vblank(vblank), .ras_x(ras_x), .ras_y(ras_y),
    .pix_in(pix_in), .pix_out(pix_out)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  function automatic int pat(input int i);
    case (i % 6)
      0: return 0;
      1: return 'hFFFF;
      2: return 'h8000;
      3: return 'h7FFF;
      4: return 'h8000 | i;
      default: return i & 'h7FFF;
    endcase
  endfunction

  // one clock: predict, advance, compare, update model
  task automatic cycle();
    int rx, ry, under, dxi, dyi, code, exp, nax, nay, naen;
    string tag;
    rx = int'(ras_x); ry = int'(ras_y); under = int'(pix_in);
    dxi = rx - ax; dyi = ry - ay;
    if (aen == 0) begin
      exp = under; tag = "R6";
    end else if (dxi < 0 || dxi > 31 || dyi < 0 || dyi > 31) begin
      exp = under; tag = "R5";
    end else begin
      code = mem[dyi * 32 + dxi];
      if (code == 0) begin exp = under; tag = "R2 R1"; end
      else if (code >= 'h8000) begin exp = code & 'h7FFF; tag = "R3 R1"; end
      else begin exp = (~under) & 'hFFFF; tag = "R4 R1"; end
    end
    if (phase_tag != "") tag = {phase_tag, " ", tag};
    nax = ax; nay = ay; naen = aen;
    if (vblank) begin nax = sx; nay = sy; naen = sen; end
    @(negedge clk);
    check(int'(pix_out), exp, {tag, " R9"});
    ax = nax; ay = nay; aen = naen;
    if (pos_we) begin sx = int'(pos_wdata[11:0]); sy = int'(pos_wdata[27:16]); end
    if (ctrl_we) sen = int'(ctrl_wdata[0]);
    if (bmp_we) mem[bmp_addr] = int'(bmp_wdata);
    bmp_we = 0; pos_we = 0; ctrl_we = 0; vblank = 0;
  endtask

  task automatic set_pos(input int x, input int y);
    pos_we = 1;
    pos_wdata = {4'hA, 12'(y), 4'h5, 12'(x)};
  endtask

  task automatic set_en(input int e);
    ctrl_we = 1;
    ctrl_wdata = {31'h2AAA_5555, 1'(e)};
  endtask

  task automatic sweep(input int x0, input int x1, input int y0, input int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        ras_x = 12'(x); ras_y = 12'(y); pix_in = 16'($urandom);
        cycle();
      end
  endtask

  task automatic retrace();
    vblank = 1; cycle();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    sx = 0; sy = 0; sen = 0; ax = 0; ay = 0; aen = 0;
    rst_n = 0; bmp_we = 0; bmp_addr = 0; bmp_wdata = 0;
    pos_we = 0; pos_wdata = 0; ctrl_we = 0; ctrl_wdata = 0;
    vblank = 0; ras_x = 0; ras_y = 0; pix_in = 16'h1234;
    repeat (3) @(negedge clk);
    check(int'(pix_out), 0, "R9 reset");
    rst_n = 1;

    // R1: fill the bitmap, cursor still disabled so output passes through
    for (int i = 0; i < 1024; i++) begin
      bmp_we = 1; bmp_addr = 10'(i); bmp_wdata = 16'(pat(i));
      ras_x = 12'(i); ras_y = 12'(i >> 3); pix_in = 16'($urandom);
      cycle();
    end

    // R7: writes outside blank do not show
    set_pos(100, 50); set_en(1); cycle();
    phase_tag = "R7";
    sweep(95, 140, 45, 60);
    phase_tag = "";
    retrace();
    sweep(90, 140, 45, 85);

    // R5: edge of coordinate space, no wrap
    set_pos(4080, 4090); cycle(); retrace();
    sweep(4070, 4095, 4085, 4095);
    sweep(0, 5, 0, 3);
    sweep(4078, 4095, 0, 2);

    // R8: hide with no position write
    set_en(0); cycle();
    phase_tag = "R7";
    sweep(4078, 4095, 4088, 4095);
    phase_tag = "R8";
    retrace();
    sweep(4078, 4095, 4088, 4095);
    set_en(1); cycle(); retrace();
    sweep(4078, 4095, 4088, 4095);
    phase_tag = "";

    // rewrite some cells then mixed random traffic
    for (int k = 0; k < 5000; k++) begin
      int r;
      r = $urandom % 100;
      if (r < 5) set_pos($urandom % 4096, $urandom % 4096);
      else if (r < 8) set_en($urandom % 4 != 0);
      else if (r < 20) begin
        bmp_we = 1; bmp_addr = 10'($urandom); bmp_wdata = 16'($urandom);
      end
      if ($urandom % 100 < 8) vblank = 1;
      ras_x = 12'(ax + int'($urandom % 44) - 6);
      ras_y = 12'(ay + int'($urandom % 44) - 6);
      pix_in = 16'($urandom);
      cycle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule